// File: doc/BRIEF.md
# Multi-Level Masked Interrupt Controller

This block collects level-sensitive hardware interrupt lines from onboard devices, seven expansion-bus levels, seven backplane levels and four asynchronous error sources. It also holds per-CPU software interrupt flip-flops. For each CPU it produces a registered 4-bit processor interrupt level. A global mask is changed only by writing ones to separate set and clear ports. A fixed table assigns every source to one of the levels 2 to 15, and several sources share some levels. Undirected hardware interrupts reach only the CPU named in a target register. Error sources are broadcast to every CPU at level 15.

Software uses a simple word-addressed register port. Writes are synchronous and reads are combinational. It unmasks the sources it serves, picks the CPU that handles device interrupts, posts software interrupts to individual CPUs, and reads the raw pending word to find out what caused an error.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, the mask reads 0xF87FFFFF, which means every implemented mask bit is set. The target reads 0, every software bit is clear and every CPU level is 0.
- R2: The global word uses the following bit positions.
  - Bit 31 is mask-all.
  - Bits 30, 29, 28 and 27 are the module, write-buffer, ECC and backplane errors.
  - Bits 22 to 14 are floppy, module, video, system timer, SCSI, audio, ethernet, serial and keyboard/mouse.
  - Expansion level x sits at bit x+7, and backplane level x sits at bit x, for x from 0 to 6.
  - A set mask bit blocks its source.
- R3: Writing to the mask-set port (address 2) sets every implemented mask bit that is 1 in the data. Bits written as 0 keep their value.
- R4: Writing to the mask-clear port (address 3) clears every mask bit that is 1 in the data. Bits written as 0 keep their value.
- R5: Sources map to levels as follows.
  - Expansion/backplane levels 0 to 6 go to levels 2, 3, 5, 7, 9, 11 and 13.
  - SCSI goes to 4, ethernet to 6, video to 8, module to 9, system timer to 10 and floppy to 11.
  - Serial and keyboard/mouse go to 12, and audio goes to 13.
- R6: Each CPU's level is the highest level that has an unmasked active source. The level is 0 when there is none.
- R7: Undirected hardware sources reach only the CPU held in the target register (address 4). A target write whose value is NCPU or more is ignored.
- R8: An active, unmasked error source drives every CPU to level 15.
- R9: While mask bit 31 is set, no global hardware source reaches any CPU. Software bits and the per-CPU timers are not affected.
- R10: Each CPU has a set port at 8+4c+1 and a clear port at 8+4c+2. Data bit 16+n sets or clears software interrupt n, for n from 1 to 15, and that interrupt raises level n. Data bits 0 to 16 are ignored.
- R11: Per-CPU timer line c raises only CPU c, at level 14. It is not masked.
- R12: Address 0 reads the raw active hardware lines ANDed with 0x787FFFFF, whether or not they are masked. Address 1 reads the mask. Address 8+4c reads CPU c's software bits in bits 31:17 and its delivered hardware level vector in bits 15:1.
- R13: The inputs are level-sensitive. Each level output is registered: it reflects the inputs and register state present at a clock edge from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | 32 | Hardware interrupt lines in global bit layout |
| cpu_tmr | input | NCPU | Per-CPU timer interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Combinational read data |
| cpu_level | output | 4*NCPU | Interrupt level per CPU, CPU c at bits 4c+3:4c |

## Verification
The bench starts with a single masked SCSI line, which separates the masked case from the unmasked one. It then unmasks the SCSI line and moves the target, which shows that steering goes to one CPU only. Expansion and backplane lines are then stacked on the same CPU, so the highest-level choice and the shared-level table are both exercised. Software bits on other CPUs, including writes to the ignored low data bits, show that each CPU's state is separate. A per-CPU timer, an ECC error, mask-all toggling and dropping an input line separate broadcast, global masking and level-sensitive behaviour from one another.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

  localparam logic [31:0] MASK_VALID = 32'hF87F_FFFF;
  localparam logic [31:0] HW_VALID   = 32'h787F_FFFF;
  localparam logic [31:0] ERR_BITS   = 32'h7800_0000;
  localparam int          MASK_ALL   = 31;

  localparam int ADR_PEND = 0;
  localparam int ADR_MASK = 1;
  localparam int ADR_MSET = 2;
  localparam int ADR_MCLR = 3;
  localparam int ADR_TGT  = 4;
  localparam int CPU_BASE = 8;
  localparam int CPU_STEP = 4;

  // level of an expansion/backplane slot x (0..6)
  function automatic logic [3:0] slot_level(input int x);
    return 4'((x < 1) ? 2 : 2 * x + 1);
  endfunction

  // level assigned to a global source bit; 0 if unused
  function automatic logic [3:0] src_level(input int b);
    logic [3:0] l;
    l = 4'd0;
    if (b < 7)        l = slot_level(b);
    else if (b < 14)  l = slot_level(b - 7);
    else begin
      case (b)
        14, 15:         l = 4'd12;
        16:             l = 4'd6;
        17:             l = 4'd13;
        18:             l = 4'd4;
        19:             l = 4'd10;
        20:             l = 4'd8;
        21:             l = 4'd9;
        22:             l = 4'd11;
        27, 28, 29, 30: l = 4'd15;
        default:        l = 4'd0;
      endcase
    end
    return l;
  endfunction

  // highest set index of a level vector (bit 0 ignored)
  function automatic logic [3:0] top_level(input logic [15:0] v);
    logic [3:0] l;
    l = 4'd0;
    for (int i = 1; i < 16; i++)
      if (v[i]) l = 4'(i);
    return l;
  endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_lvl_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int TGT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic             tgt_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      mask_q,
  output logic [TGT_W-1:0] target_q
);

  logic tgt_ok;
  assign tgt_ok = (wdata < 32'(NCPU));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= MASK_VALID;
      target_q <= '0;
    end else begin
      if (set_we)      mask_q <= mask_q | (wdata & MASK_VALID);
      else if (clr_we) mask_q <= mask_q & ~(wdata & MASK_VALID);
      if (tgt_we && tgt_ok) target_q <= wdata[TGT_W-1:0];
    end
  end

endmodule

// File: rtl/irq_soft_bits.sv
module irq_soft_bits (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_we,
  input  logic        clr_we,
  input  logic [31:0] wdata,
  output logic [15:0] soft_q
);

  logic [15:0] req;
  assign req = wdata[31:16] & 16'hFFFE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      soft_q <= '0;
    else if (set_we) soft_q <= soft_q | req;
    else if (clr_we) soft_q <= soft_q & ~req;
  end

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_lvl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] lvl_vec,
  output logic [3:0]  level_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 4'd0;
    else        level_q <= top_level(lvl_vec);
  end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         hw_irq,
  input  logic [NCPU-1:0]     cpu_tmr,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic [4*NCPU-1:0]   cpu_level
);

  localparam int TGT_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic [31:0]        mask_q;
  logic [TGT_W-1:0]   target_q;
  logic [31:0]        hw_raw;
  logic [31:0]        hw_live;
  logic               err_live;
  logic [15:0]        undirected_vec;
  logic [16*NCPU-1:0] soft_flat;
  logic [16*NCPU-1:0] hwvec_flat;

  logic wr_mset, wr_mclr, wr_tgt;
  assign wr_mset = wr_en && (wr_addr == ADDR_W'(ADR_MSET));
  assign wr_mclr = wr_en && (wr_addr == ADDR_W'(ADR_MCLR));
  assign wr_tgt  = wr_en && (wr_addr == ADDR_W'(ADR_TGT));

  irq_mask_bank #(.NCPU(NCPU), .TGT_W(TGT_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_we(wr_mset), .clr_we(wr_mclr),
    .tgt_we(wr_tgt), .wdata(wr_data), .mask_q(mask_q), .target_q(target_q)
  );

  assign hw_raw   = hw_irq & HW_VALID;
  assign hw_live  = hw_raw & ~mask_q & {32{~mask_q[MASK_ALL]}};
  assign err_live = |(hw_live & ERR_BITS);

  always_comb begin
    undirected_vec = '0;
    for (int b = 0; b < 31; b++)
      if (hw_live[b] && !ERR_BITS[b])
        undirected_vec[src_level(b)] = 1'b1;
    undirected_vec[0] = 1'b0;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(CPU_BASE + CPU_STEP * c + 1);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CPU_BASE + CPU_STEP * c + 2);

    logic [15:0] soft_q;
    logic [15:0] hw_vec;
    logic        is_tgt;

    irq_soft_bits u_soft (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_en && (wr_addr == A_SET)),
      .clr_we(wr_en && (wr_addr == A_CLR)),
      .wdata(wr_data), .soft_q(soft_q)
    );

    assign is_tgt = (target_q == TGT_W'(c));

    always_comb begin
      hw_vec = is_tgt ? undirected_vec : 16'h0000;
      if (cpu_tmr[c]) hw_vec[14] = 1'b1;
      if (err_live)   hw_vec[15] = 1'b1;
    end

    irq_level_pick u_pick (
      .clk(clk), .rst_n(rst_n), .lvl_vec(hw_vec | soft_q),
      .level_q(cpu_level[4*c +: 4])
    );

    assign soft_flat[16*c +: 16]  = soft_q;
    assign hwvec_flat[16*c +: 16] = hw_vec;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADR_PEND)) rd_data = hw_raw;
    if (rd_addr == ADDR_W'(ADR_MASK)) rd_data = mask_q;
    if (rd_addr == ADDR_W'(ADR_TGT))  rd_data = 32'(target_q);
    for (int c = 0; c < NCPU; c++)
      if (rd_addr == ADDR_W'(CPU_BASE + CPU_STEP * c))
        rd_data = {soft_flat[16*c +: 16], hwvec_flat[16*c +: 16]};
  end

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_lvl_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 6,
  parameter int TGT_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [31:0]        wr_data,
  input logic [31:0]        mask_q,
  input logic [TGT_W-1:0]   target_q,
  input logic [16*NCPU-1:0] soft_flat,
  input logic [NCPU-1:0]    cpu_tmr,
  input logic [4*NCPU-1:0]  cpu_level,
  input logic               err_live
);

  // R3: set port sets exactly the written implemented bits
  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_MSET)) |=>
      ((mask_q & $past(wr_data) & MASK_VALID) == ($past(wr_data) & MASK_VALID)));

  // R4: clear port clears the written bits
  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_MCLR)) |=> ((mask_q & $past(wr_data)) == 32'h0));

  // R7: out-of-range target write leaves the target alone
  assert_tgt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_TGT) && wr_data >= 32'(NCPU)) |=> $stable(target_q));

  for (genvar c = 0; c < NCPU; c++) begin : g_a
    // R8: live error forces level 15 everywhere
    assert_err_bcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_live |=> (cpu_level[4*c +: 4] == 4'd15));

    // R9: mask-all with no soft bit and no timer gives level 0
    assert_mask_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[31] && soft_flat[16*c +: 16] == 16'h0 && !cpu_tmr[c]) |=>
        (cpu_level[4*c +: 4] == 4'd0));
  end

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mask_q(mask_q), .target_q(target_q), .soft_flat(soft_flat), .cpu_tmr(cpu_tmr),
  .cpu_level(cpu_level), .err_live(err_live)
);

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;

  localparam int NCPU = 4;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     hw_irq = '0;
  logic [NCPU-1:0] cpu_tmr = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [31:0]     rd_data;
  logic [4*NCPU-1:0] cpu_level;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  irq_level_ctrl #(.NCPU(NCPU), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .cpu_tmr(cpu_tmr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cpu_level(cpu_level)
  );

  always #5 clk = ~clk;

  task automatic push(input bit r, input logic [31:0] e, input string t);
    item_t it;
    it.is_rd = r; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic expect_lv(input logic [31:0] e, input string t);
    push(1'b0, e, t);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_addr = AW'(a);
    push(1'b1, e, t);
  endtask

  task automatic set_hw(input logic [31:0] v);
    @(negedge clk);
    hw_irq = v;
  endtask

  // monitor: compare 3 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = sb.pop_front();
        got = it.is_rd ? rd_data : 32'(cpu_level);
        tests++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s: got %08h expected %08h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_lv(32'h0, "R1 levels after reset");
    rd(1, 32'hF87F_FFFF, "R1 mask after reset");
    rd(4, 32'h0, "R1 target after reset");

    set_hw(32'h0004_0000);
    expect_lv(32'h0, "R2 masked SCSI gives no level");
    rd(0, 32'h0004_0000, "R12 raw pending shows masked line");

    wr(3, 32'h8004_0000);
    expect_lv(32'h0004, "R4 R5 unmask SCSI level 4 on cpu0");
    rd(1, 32'h787B_FFFF, "R4 mask after clear");

    wr(4, 32'd2);
    expect_lv(32'h0400, "R7 steer to cpu2");
    wr(4, 32'd7);
    expect_lv(32'h0400, "R7 out-of-range target ignored");
    rd(4, 32'd2, "R7 target readback");

    set_hw(32'h0004_1000);
    expect_lv(32'h0400, "R2 masked expansion level 5");
    wr(3, 32'h0000_1000);
    expect_lv(32'h0B00, "R5 R6 expansion level 5 gives 11");
    set_hw(32'h0004_1040);
    wr(3, 32'h0000_0040);
    expect_lv(32'h0D00, "R6 backplane level 6 gives 13");
    rd(16, 32'h0000_2810, "R12 cpu2 level vector");

    wr(13, 32'h0008_0000);
    expect_lv(32'h0D30, "R10 soft 3 on cpu1");
    rd(12, 32'h0008_0000, "R12 cpu1 soft bits");
    wr(21, 32'h0001_FFFF);
    expect_lv(32'h0D30, "R10 low data bits ignored");
    rd(20, 32'h0, "R10 cpu3 stays empty");

    @(negedge clk);
    cpu_tmr = 4'b0001;
    expect_lv(32'h0D3E, "R11 timer level 14 on cpu0 only");

    set_hw(32'h1004_1040);
    expect_lv(32'h0D3E, "R2 masked ECC error");
    wr(3, 32'h1000_0000);
    expect_lv(32'hFFFF, "R8 error broadcast level 15");
    rd(0, 32'h1004_1040, "R12 raw pending with error");

    wr(2, 32'h8000_0000);
    expect_lv(32'h003E, "R9 mask-all keeps soft and timer");
    rd(1, 32'hE87B_EFBF, "R3 mask after set");

    wr(14, 32'h0008_0000);
    expect_lv(32'h000E, "R10 soft clear on cpu1");

    wr(3, 32'h8000_0000);
    expect_lv(32'hFFFF, "R9 mask-all released");
    set_hw(32'h0004_1040);
    expect_lv(32'h0D0E, "R13 level follows dropped error line");
    wr(2, 32'h0000_0040);
    expect_lv(32'h0B0E, "R3 remask backplane level 6");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule